// File: doc/BRIEF.md
# SPI Mode-1 Configuration Slave

This block lets a host processor read and write an on-chip register space over a four-wire serial link. The link uses clock polarity 0 and clock phase 1. The slave takes in data bits on the falling edge of the serial clock and changes its output bit after the rising edge. Each transfer opens with a 32-bit control word and continues with 32-bit data words, most significant bit first. The control word gives the direction, the number of data words and the starting word address. The block turns each data word into one cycle on a simple request/acknowledge register bus, and it moves the address forward by one after each word.

All serial inputs are brought into the system clock domain through synchronizer stages and then edge-detected. The system clock must therefore run at least several times faster than the serial clock. On a read, the first register is fetched as soon as the control word is complete. Each later register is fetched while the word before it is being shifted out. The host has to leave a pause between the control word and the first data word that covers the bus latency. When a transfer ends, its total length is checked, and a status output reports whether the length was legal.

Top module: `spi_cfg_slave`

## Requirements
- R1: The control word is sampled MSB first on falling serial-clock edges. Its fields are: bit 31 selects write (1) or read (0), bits 30:25 hold the word count minus one (so 1 to 64 words), and bits 24:4 hold the starting word address. Bits 3:0 have no effect.
- R2: In a write, data word k (counting from 0) issues exactly one bus write once its 32nd bit has been sampled. It goes to the start address plus k, modulo 2^21, and carries the word as received.
- R3: Data words past the word count cause no bus cycle in a write and read back as all zeros in a read.
- R4: In a read, data word k returns the register at the start address plus k, modulo 2^21, MSB first, with each bit changing after a rising serial-clock edge. The first fetch is issued when the control word completes.
- R5: The data output stays low while the slave is deselected and during the whole control word.
- R6: In a read, if a data word's fetch has not returned by that word's first rising clock edge, that word and every later word of the transfer read as zeros.
- R7: The bus request stays high, with address, direction and write data held stable, until the cycle in which the acknowledge is sampled high. At most one request is outstanding at a time.
- R8: When the slave select returns high, the error output is set to 1 if the number of sampled bits is below 64, above 2080 or not a multiple of 32. It is set to 0 otherwise. It does not change at any other time.
- R9: A trailing partial data word is discarded and causes no bus write.
- R10: After reset, the bus request, the data output and the error output are all low.
- R11: A transfer shorter than one full control word issues no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 21 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request accepted; read data valid in this cycle |
| bus_rdata | input | 32 | Read data |
| xfer_err | output | 1 | Length error of the most recently ended transfer |

## Verification
The bench builds the slave with its default parameters: two synchronizer stages, a 64-bit minimum and a 2080-bit maximum transfer. These defaults allow a full 64-word read, which is exactly 2080 bits, and a 66-word write that overruns to 2112 bits, both within the run time. With a serial clock period of twelve system clocks, the synchronizer and output register latency fits inside one half period. The bench's bus latency setting can also be raised above the pause the host leaves after the control word, so a read fetch can be made to miss its word.

// File: rtl/spi_cfg_pkg.sv
// Package: shared constants and helpers for the SPI configuration slave.
// Assumes the fixed 32-bit word framing and control field positions below.
package spi_cfg_pkg;

    localparam int WORD_W      = 32;
    localparam int POS_W       = $clog2(WORD_W);
    localparam int CTL_ADDR_W  = 21;
    localparam int CTL_CNT_W   = 6;
    localparam int CTL_WR_BIT  = 31;
    localparam int CTL_CNT_HI  = 30;
    localparam int CTL_CNT_LO  = 25;
    localparam int CTL_ADDR_HI = 24;
    localparam int CTL_ADDR_LO = 4;

    // Decoded word count (field holds count minus one)
    function automatic logic [CTL_CNT_W:0] words_from_field(input logic [CTL_CNT_W-1:0] fld);
        return {1'b0, fld} + {{CTL_CNT_W{1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
// Module: spi_cfg_sync
// Brings the three serial inputs into the system clock domain through a
// chain of STAGES flops. All three share one chain depth, so they stay
// aligned with each other. Assumes STAGES >= 1.
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic sck_o,
    output logic ss_n_o,
    output logic mosi_o
);
    localparam logic [2:0] IDLE_V = 3'b010;   // sck low, ss_n high, mosi low

    logic [2:0] chain [STAGES];

    // Purpose: shift the input vector through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_V;
        end else begin
            chain[0] <= {sck_i, ss_n_i, mosi_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sck_o  = chain[STAGES-1][2];
    assign ss_n_o = chain[STAGES-1][1];
    assign mosi_o = chain[STAGES-1][0];
endmodule

// File: rtl/spi_cfg_shifter.sv
// Module: spi_cfg_shifter
// Detects serial clock edges in the system domain. On falling edges it
// shifts in bits, counts them and reports each completed word. On rising
// edges it shifts out the reply, loading a fresh word at the start of every
// data word. Assumes synchronized inputs and a serial clock slow enough that
// each edge is seen on its own.
module spi_cfg_shifter
    import spi_cfg_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sck_s,
    input  logic                   ss_n_s,
    input  logic                   mosi_s,
    input  logic [WORD_W-1:0]      load_word,
    output logic                   word_done,
    output logic [WORD_W-1:0]      word_data,
    output logic [CNT_W-POS_W-1:0] word_idx,
    output logic                   tx_start,
    output logic                   xfer_end,
    output logic [CNT_W-1:0]       end_bits,
    output logic                   miso
);
    localparam int IDX_W = CNT_W - POS_W;

    logic              sck_q, ss_n_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh, tx_sh;
    logic              fall, rise, sat;

    assign fall     = sck_q & ~sck_s & ~ss_n_s;
    assign rise     = ~sck_q & sck_s & ~ss_n_s;
    assign sat      = &bit_cnt;
    assign tx_start = rise && (bit_cnt[POS_W-1:0] == '0)
                      && (bit_cnt[CNT_W-1:POS_W] != '0) && !sat;
    assign xfer_end = ss_n_s & ~ss_n_q;
    assign end_bits = bit_cnt;
    assign miso     = tx_sh[WORD_W-1];

    // Purpose: keep previous samples for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            ss_n_q <= 1'b1;
        end else begin
            sck_q  <= sck_s;
            ss_n_q <= ss_n_s;
        end
    end

    // Purpose: receive shift, bit counting, word completion and transmit shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            word_done <= 1'b0;
            word_data <= '0;
            word_idx  <= '0;
        end else begin
            word_done <= 1'b0;
            if (ss_n_s) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (fall && !sat) begin
                    rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (&bit_cnt[POS_W-1:0]) begin
                        word_done <= 1'b1;
                        word_data <= {rx_sh[WORD_W-2:0], mosi_s};
                        word_idx  <= bit_cnt[CNT_W-1:POS_W];
                    end
                end
                if (rise) tx_sh <= tx_start ? load_word : {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Output is quiet through the whole control word
    assert_ctl_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CNT_W'(WORD_W)) |-> !miso);

    // A completed word always leaves the count on a word boundary
    assert_word_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (bit_cnt[POS_W-1:0] == '0) && (bit_cnt[CNT_W-1:POS_W] == word_idx + IDX_W'(1)));
endmodule

// File: rtl/spi_cfg_ctrl.sv
// Module: spi_cfg_ctrl
// Decodes the control word and runs the register bus: one write per
// in-range data word, and read prefetch one word ahead. It also checks the
// transfer length when the slave is deselected. Assumes the bus acknowledges
// each request within one serial word time and that the previous transfer's
// request has finished before the next control word completes.
module spi_cfg_ctrl
    import spi_cfg_pkg::*;
#(
    parameter int CNT_W    = 13,
    parameter int MIN_BITS = 64,
    parameter int MAX_BITS = 2080
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_done,
    input  logic [WORD_W-1:0]      word_data,
    input  logic [CNT_W-POS_W-1:0] word_idx,
    input  logic                   tx_start,
    input  logic                   xfer_end,
    input  logic [CNT_W-1:0]       end_bits,
    output logic [WORD_W-1:0]      load_word,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [CTL_ADDR_W-1:0]  bus_addr,
    output logic [WORD_W-1:0]      bus_wdata,
    input  logic                   bus_ack,
    input  logic [WORD_W-1:0]      bus_rdata,
    output logic                   xfer_err
);
    localparam int IDX_W = CNT_W - POS_W;

    logic                  active, is_wr, rbuf_vld, rd_dead;
    logic [CTL_CNT_W:0]    n_words, fetched;
    logic [CTL_ADDR_W-1:0] nxt_addr;
    logic [WORD_W-1:0]     rbuf;
    logic                  ctl_hit, wr_hit, len_ok;
    logic                  ctl_wr;
    logic [CTL_ADDR_W-1:0] ctl_addr;

    assign ctl_wr   = word_data[CTL_WR_BIT];
    assign ctl_addr = word_data[CTL_ADDR_HI:CTL_ADDR_LO];
    assign ctl_hit  = word_done && (word_idx == '0);
    assign wr_hit   = word_done && active && is_wr && (word_idx != '0)
                      && (word_idx <= IDX_W'(n_words));
    assign len_ok   = (end_bits >= CNT_W'(MIN_BITS)) && (end_bits <= CNT_W'(MAX_BITS))
                      && (end_bits[POS_W-1:0] == '0);
    assign load_word = (active && !is_wr && rbuf_vld && !rd_dead) ? rbuf : '0;

    // Purpose: transfer decode, bus handshake, read prefetch and length status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            is_wr     <= 1'b0;
            rbuf_vld  <= 1'b0;
            rd_dead   <= 1'b0;
            n_words   <= '0;
            fetched   <= '0;
            nxt_addr  <= '0;
            rbuf      <= '0;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            xfer_err  <= 1'b0;
        end else begin
            if (bus_ack) begin
                bus_req <= 1'b0;
                if (!bus_we && active && !rd_dead && !tx_start) begin
                    rbuf     <= bus_rdata;
                    rbuf_vld <= 1'b1;
                end
            end
            if (ctl_hit) begin
                active   <= 1'b1;
                is_wr    <= ctl_wr;
                n_words  <= words_from_field(word_data[CTL_CNT_HI:CTL_CNT_LO]);
                rd_dead  <= 1'b0;
                rbuf_vld <= 1'b0;
                if (!ctl_wr) begin
                    bus_req  <= 1'b1;
                    bus_we   <= 1'b0;
                    bus_addr <= ctl_addr;
                    nxt_addr <= ctl_addr + 1'b1;
                    fetched  <= (CTL_CNT_W+1)'(1);
                end else begin
                    nxt_addr <= ctl_addr;
                    fetched  <= '0;
                end
            end
            if (wr_hit) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= nxt_addr;
                bus_wdata <= word_data;
                nxt_addr  <= nxt_addr + 1'b1;
            end
            if (tx_start && active && !is_wr) begin
                if (rbuf_vld && !rd_dead) begin
                    rbuf_vld <= 1'b0;
                    if (fetched < n_words) begin
                        bus_req  <= 1'b1;
                        bus_we   <= 1'b0;
                        bus_addr <= nxt_addr;
                        nxt_addr <= nxt_addr + 1'b1;
                        fetched  <= fetched + 1'b1;
                    end
                end else begin
                    rd_dead <= 1'b1;
                end
            end
            if (xfer_end) begin
                active   <= 1'b0;
                rbuf_vld <= 1'b0;
                xfer_err <= !len_ok;
            end
        end
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_write_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> bus_req && bus_we && (bus_wdata == $past(word_data)));

    assert_read_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && !word_data[CTL_WR_BIT]) |=> bus_req && !bus_we
            && (bus_addr == $past(word_data[CTL_ADDR_HI:CTL_ADDR_LO])));

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_end |=> $stable(xfer_err));

    assert_req_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(word_done || tx_start));
endmodule

// File: rtl/spi_cfg_slave.sv
// Module: spi_cfg_slave (top)
// SPI mode-1 configuration slave: synchronizer, bit shifter and bus
// controller. Assumes clk is at least about eight times the serial clock.
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_BITS    = 64,
    parameter int MAX_BITS    = 2080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_ss_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        bus_req,
    output logic        bus_we,
    output logic [20:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        xfer_err
);
    localparam int CNT_W = $clog2(MAX_BITS + 1) + 1;
    localparam int IDX_W = CNT_W - POS_W;

    logic              sck_s, ss_n_s, mosi_s;
    logic              word_done, tx_start, xfer_end;
    logic [WORD_W-1:0] word_data, load_word;
    logic [IDX_W-1:0]  word_idx;
    logic [CNT_W-1:0]  end_bits;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck), .ss_n_i(spi_ss_n), .mosi_i(spi_mosi),
        .sck_o(sck_s), .ss_n_o(ss_n_s), .mosi_o(mosi_s)
    );

    spi_cfg_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_s(sck_s), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
        .load_word(load_word),
        .word_done(word_done), .word_data(word_data), .word_idx(word_idx),
        .tx_start(tx_start), .xfer_end(xfer_end), .end_bits(end_bits),
        .miso(spi_miso)
    );

    spi_cfg_ctrl #(.CNT_W(CNT_W), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .word_done(word_done), .word_data(word_data), .word_idx(word_idx),
        .tx_start(tx_start), .xfer_end(xfer_end), .end_bits(end_bits),
        .load_word(load_word),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .xfer_err(xfer_err)
    );
endmodule

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_sck, spi_ss_n, spi_mosi, spi_miso;
    logic        bus_req, bus_we, bus_ack, xfer_err;
    logic [20:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int bus_lat = 1;
    int lat_cnt = 0;
    int n_rd = 0;
    int wlog_n = 0;
    logic [20:0] wlog_addr [0:127];
    logic [31:0] wlog_data [0:127];
    logic [31:0] tx_words [0:71];
    logic [31:0] rx_words [0:71];

    always #10 clk = ~clk;

    spi_cfg_slave u_spi_cfg_slave (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .xfer_err(xfer_err)
    );

    function automatic logic [31:0] rd_model(input logic [20:0] a);
        return {a[10:0], a} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] ctl(input bit wr, input int n, input logic [20:0] a, input logic [3:0] rs);
        logic [5:0] f;
        f = 6'(n - 1);
        return {wr, f, a, rs};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Register bus model: acknowledges after bus_lat idle cycles
    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (lat_cnt >= bus_lat) begin
                    bus_ack = 1'b1;
                    lat_cnt = 0;
                    if (bus_we) begin
                        if (wlog_n < 128) begin
                            wlog_addr[wlog_n] = bus_addr;
                            wlog_data[wlog_n] = bus_wdata;
                        end
                        wlog_n++;
                    end else begin
                        bus_rdata = rd_model(bus_addr);
                        n_rd++;
                    end
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    // Host side of one transfer: nbits clocks, gap clocks after the control word
    task automatic spi_xfer(input int nbits, input int gap);
        for (int w = 0; w < 72; w++) rx_words[w] = '0;
        wlog_n = 0;
        n_rd = 0;
        spi_ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b1;
            spi_mosi = tx_words[i / 32][31 - (i % 32)];
            repeat (HALF) @(negedge clk);
            rx_words[i / 32][31 - (i % 32)] = spi_miso;
            spi_sck = 1'b0;
            repeat (HALF) @(negedge clk);
            if (i == 31) repeat (gap) @(negedge clk);
        end
        spi_ss_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [20:0] a;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        spi_sck = 1'b0;
        spi_ss_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R10 miso", {31'd0, spi_miso}, 32'd0);
        chk("R10 xfer_err", {31'd0, xfer_err}, 32'd0);

        // R4 R8: maximum legal read, 64 words, address wraps through 2^21
        bus_lat = 2;
        a = 21'h1FFFF0;
        tx_words[0] = ctl(1'b0, 64, a, 4'h0);
        for (int k = 1; k <= 64; k++) tx_words[k] = 32'hFFFF_FFFF;
        spi_xfer(65 * 32, 24);
        chk("R8 2080 bits ok", {31'd0, xfer_err}, 32'd0);
        chk("R5 control word quiet", rx_words[0], 32'd0);
        for (int k = 1; k <= 64; k++) chk("R4 long read", rx_words[k], rd_model(a + 21'(k - 1)));

        // R3 R8: 66-word write with count 64 overruns the maximum
        a = 21'h000100;
        tx_words[0] = ctl(1'b1, 64, a, 4'h0);
        for (int k = 1; k <= 65; k++) tx_words[k] = $urandom;
        spi_xfer(66 * 32, 0);
        chk("R8 2112 bits err", {31'd0, xfer_err}, 32'd1);
        chk("R3 write count capped", wlog_n, 32'd64);
        chk("R2 last write addr", {11'd0, wlog_addr[63]}, {11'd0, a + 21'd63});
        chk("R2 last write data", wlog_data[63], tx_words[64]);

        // R11: partial control word
        tx_words[0] = ctl(1'b0, 4, 21'h00AAA, 4'h0);
        spi_xfer(20, 0);
        chk("R11 short no read", n_rd, 32'd0);
        chk("R8 short err", {31'd0, xfer_err}, 32'd1);

        // R8 R11: control word alone (32 bits) is below minimum
        tx_words[0] = ctl(1'b1, 1, 21'h00055, 4'h0);
        spi_xfer(32, 0);
        chk("R8 32 bits err", {31'd0, xfer_err}, 32'd1);
        chk("R11 ctl only no write", wlog_n, 32'd0);

        // R9: one full data word then a partial one
        tx_words[0] = ctl(1'b1, 3, 21'h00200, 4'h0);
        tx_words[1] = 32'hDEAD_BEEF;
        tx_words[2] = 32'h1234_5678;
        spi_xfer(64 + 10, 0);
        chk("R9 partial dropped", wlog_n, 32'd1);
        chk("R8 non multiple err", {31'd0, xfer_err}, 32'd1);

        // R1 R8: reserved bits set, legal write clears the error
        tx_words[0] = ctl(1'b1, 2, 21'h0ABCD, 4'hF);
        tx_words[1] = 32'h0BAD_F00D;
        tx_words[2] = 32'hCAFE_0001;
        spi_xfer(96, 0);
        chk("R8 legal clears err", {31'd0, xfer_err}, 32'd0);
        chk("R1 reserved ignored count", wlog_n, 32'd2);
        chk("R1 address decode", {11'd0, wlog_addr[0]}, {11'd0, 21'h0ABCD});
        chk("R2 second addr", {11'd0, wlog_addr[1]}, {11'd0, 21'h0ABCE});
        chk("R2 second data", wlog_data[1], 32'hCAFE_0001);

        // R6: no gap and slow bus, fetch misses the first data word
        bus_lat = 30;
        tx_words[0] = ctl(1'b0, 3, 21'h00300, 4'h0);
        for (int k = 1; k <= 3; k++) tx_words[k] = '0;
        spi_xfer(4 * 32, 0);
        for (int k = 1; k <= 3; k++) chk("R6 late read zeros", rx_words[k], 32'd0);
        chk("R6 no further fetch", n_rd, 32'd1);
        repeat (40) @(negedge clk);

        // R3: read with two words past the count
        bus_lat = 1;
        a = 21'h01234;
        tx_words[0] = ctl(1'b0, 2, a, 4'h0);
        spi_xfer(5 * 32, 24);
        chk("R4 read w1", rx_words[1], rd_model(a));
        chk("R4 read w2", rx_words[2], rd_model(a + 21'd1));
        chk("R3 extra read w3", rx_words[3], 32'd0);
        chk("R3 extra read w4", rx_words[4], 32'd0);

        // Random transfers (R1 R2 R3 R4 R5 R8)
        for (int t = 0; t < 16; t++) begin
            bit wr;
            int n, extra;
            wr = 1'($urandom);
            n = 1 + ($urandom % 8);
            extra = $urandom % 2;
            a = 21'($urandom);
            bus_lat = $urandom % 4;
            tx_words[0] = ctl(wr, n, a, 4'($urandom));
            for (int k = 1; k <= n + extra; k++) tx_words[k] = $urandom;
            spi_xfer((1 + n + extra) * 32, 24);
            chk("R8 random ok", {31'd0, xfer_err}, 32'd0);
            chk("R5 random control quiet", rx_words[0], 32'd0);
            if (wr) begin
                chk("R3 random write count", wlog_n, n);
                for (int k = 0; k < n; k++) begin
                    chk("R2 random addr", {11'd0, wlog_addr[k]}, {11'd0, a + 21'(k)});
                    chk("R2 random data", wlog_data[k], tx_words[k + 1]);
                end
            end else begin
                for (int k = 1; k <= n; k++) chk("R4 random read", rx_words[k], rd_model(a + 21'(k - 1)));
                if (extra != 0) chk("R3 random extra zero", rx_words[n + 1], 32'd0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule